// File: doc/BRIEF.md
# Indirect Register Window for an 8-bit Host Bus

This block lets a host with a narrow parallel bus reach a large bank of internal 8-bit registers through only two bus locations. The first location is a pointer: its low seven bits name one of 128 internal registers. Its top bit says whether the host intends to read or to write that register next. The second location is a data window onto the register named by the pointer.

When the host writes the pointer with the read flag set, the block copies the named register into its data holding register on the same clock edge. The host's following read of the data location is then answered directly from that holding register, with no wait state and no extra clock. When the pointer carries the write flag instead, a host write to the data location lands in the named internal register on the clock edge of the write. A data write made while the read flag is set is discarded.

Top module: `ireg_port`

## Requirements
- R1: A host read of the pointer location (`bus_loc` = 0) returns the full 8-bit value last written to it, flag bit included.
- R2: Bits 6..0 of the pointer select one of 128 internal registers (address 0 to 127), and each register keeps its own value independently of the others.
- R3: Bit 7 of the pointer is the direction flag: 1 means read mode, 0 means write mode.
- R4: Writing the pointer with bit 7 = 1 loads the selected register's current value into the data holding register on that same clock edge, so that the next read of the data location (`bus_loc` = 1) returns it.
- R5: In write mode, a host write to the data location stores the byte into the selected register and into the data holding register on the clock edge of the write.
- R6: In read mode, a host write to the data location changes neither any internal register nor the data holding register.
- R7: A host read is answered combinationally in the cycle its strobe is asserted and has no side effect: repeated reads return the same value and leave the pointer unchanged.
- R8: Reset (`rst_n` = 0) clears the pointer, the data holding register and all 128 internal registers to zero.
- R9: With `bus_sel` low, write strobes have no effect and `bus_dout` is zero; `bus_dout` is also zero whenever no read strobe is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Chip select, active high |
| bus_loc | input | 1 | Location select: 0 = pointer, 1 = data window |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wr | input | 1 | Write strobe, active high; one write per cycle it is high |
| bus_din | input | 8 | Byte written by the host |
| bus_dout | output | 8 | Byte returned to the host during a read |

## Verification
The assertions assume the inputs are sampled once per clock and that a write strobe held for one cycle means exactly one write; they place no demand on holding data stable across cycles. The bench always drives the bus on the falling clock edge and holds each strobe for one cycle only, so every write is counted once and read results are sampled well before the next rising edge. Read and write strobes are never raised together, since their combined meaning is not a requirement.

// File: rtl/ireg_pkg.sv
package ireg_pkg;

  // Host-visible location encoding on bus_loc
  typedef enum logic {
    LOC_POINTER = 1'b0,
    LOC_WINDOW  = 1'b1
  } loc_e;

  // Direction flag carried in the pointer's top bit
  typedef enum logic {
    DIR_WRITE = 1'b0,
    DIR_READ  = 1'b1
  } dir_e;

  localparam int unsigned BUS_W_DEFAULT = 8;

endpackage

// File: rtl/ireg_decode.sv
module ireg_decode (
  input  logic bus_sel,
  input  logic bus_loc,
  input  logic bus_rd,
  input  logic bus_wr,
  input  logic din_dir,
  input  logic ptr_dir,
  output logic ptr_wr_evt,
  output logic fetch_evt,
  output logic store_evt,
  output logic drop_evt,
  output logic rd_evt
);
  import ireg_pkg::*;

  logic win_wr;

  always_comb begin
    ptr_wr_evt = bus_sel && bus_wr && (loc_e'(bus_loc) == LOC_POINTER);
    win_wr     = bus_sel && bus_wr && (loc_e'(bus_loc) == LOC_WINDOW);
    fetch_evt  = ptr_wr_evt && (dir_e'(din_dir) == DIR_READ);
    store_evt  = win_wr && (dir_e'(ptr_dir) == DIR_WRITE);
    drop_evt   = win_wr && (dir_e'(ptr_dir) == DIR_READ);
    rd_evt     = bus_sel && bus_rd;
  end

endmodule

// File: rtl/ireg_pointer.sv
module ireg_pointer #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] ptr_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)    ptr_q <= '0;
    else if (load) ptr_q <= din;
  end

endmodule

// File: rtl/ireg_bank.sv
module ireg_bank #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    waddr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [ADDR_W-1:0]    raddr,
  output logic [DATA_W-1:0]    rdata,
  output logic [(2**ADDR_W)-1:0] we_vec
);
  localparam int unsigned NUM_REGS = 2 ** ADDR_W;

  logic [DATA_W-1:0] regs [NUM_REGS];

  // one-hot write enable for a single target register
  function automatic logic [NUM_REGS-1:0] dec_onehot(input logic en,
                                                     input logic [ADDR_W-1:0] a);
    logic [NUM_REGS-1:0] v;
    v = '0;
    if (en) v[a] = 1'b1;
    return v;
  endfunction

  assign we_vec = dec_onehot(we, waddr);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)        regs[g] <= '0;
      else if (we_vec[g]) regs[g] <= wdata;
    end
  end

  assign rdata = regs[raddr];

endmodule

// File: rtl/ireg_window.sv
module ireg_window #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch,
  input  logic [DATA_W-1:0] fetch_data,
  input  logic              store,
  input  logic [DATA_W-1:0] store_data,
  output logic [DATA_W-1:0] win_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)      win_q <= '0;
    else if (fetch)  win_q <= fetch_data;
    else if (store)  win_q <= store_data;
  end

endmodule

// File: rtl/ireg_port.sv
module ireg_port #(
  parameter int unsigned DATA_W = ireg_pkg::BUS_W_DEFAULT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_loc,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_din,
  output logic [DATA_W-1:0] bus_dout
);
  import ireg_pkg::*;

  localparam int unsigned ADDR_W   = DATA_W - 1;
  localparam int unsigned NUM_REGS = 2 ** ADDR_W;
  localparam int unsigned DIR_BIT  = DATA_W - 1;

  function automatic logic [ADDR_W-1:0] ptr_addr(input logic [DATA_W-1:0] p);
    return p[ADDR_W-1:0];
  endfunction

  function automatic logic ptr_dir_of(input logic [DATA_W-1:0] p);
    return p[DIR_BIT];
  endfunction

  logic [DATA_W-1:0]   ptr_q;
  logic [DATA_W-1:0]   win_q;
  logic [DATA_W-1:0]   bank_rdata;
  logic [NUM_REGS-1:0] bank_we;
  logic ptr_wr_evt, fetch_evt, store_evt, drop_evt, rd_evt;

  ireg_decode u_dec (
    .bus_sel    (bus_sel),
    .bus_loc    (bus_loc),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .din_dir    (ptr_dir_of(bus_din)),
    .ptr_dir    (ptr_dir_of(ptr_q)),
    .ptr_wr_evt (ptr_wr_evt),
    .fetch_evt  (fetch_evt),
    .store_evt  (store_evt),
    .drop_evt   (drop_evt),
    .rd_evt     (rd_evt)
  );

  ireg_pointer #(.DATA_W(DATA_W)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (ptr_wr_evt),
    .din   (bus_din),
    .ptr_q (ptr_q)
  );

  // read port is addressed by the incoming pointer byte so the fetch
  // completes on the same edge the pointer is written
  ireg_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (store_evt),
    .waddr  (ptr_addr(ptr_q)),
    .wdata  (bus_din),
    .raddr  (ptr_addr(bus_din)),
    .rdata  (bank_rdata),
    .we_vec (bank_we)
  );

  ireg_window #(.DATA_W(DATA_W)) u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch      (fetch_evt),
    .fetch_data (bank_rdata),
    .store      (store_evt),
    .store_data (bus_din),
    .win_q      (win_q)
  );

  always_comb begin
    if (!rd_evt)                               bus_dout = '0;
    else if (loc_e'(bus_loc) == LOC_POINTER)   bus_dout = ptr_q;
    else                                       bus_dout = win_q;
  end

endmodule

// File: rtl/ireg_port_chk.sv
module ireg_port_chk #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_REGS = 128
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_sel,
  input logic [DATA_W-1:0]   bus_din,
  input logic [DATA_W-1:0]   ptr_q,
  input logic [DATA_W-1:0]   win_q,
  input logic                ptr_wr_evt,
  input logic                fetch_evt,
  input logic                store_evt,
  input logic                drop_evt,
  input logic [NUM_REGS-1:0] bank_we
);

  p_ptr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ptr_wr_evt |=> $stable(ptr_q));

  p_ptr_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr_evt |=> ptr_q == $past(bus_din));

  p_one_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we));

  p_we_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_we != '0) |-> !ptr_q[DATA_W-1]);

  p_fetch_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_evt |-> bus_din[DATA_W-1]);

  p_store_win_r5: assert property (@(posedge clk) disable iff (!rst_n)
    store_evt |=> win_q == $past(bus_din));

  p_drop_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> $stable(win_q));

  p_drop_no_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |-> bank_we == '0);

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> $stable(ptr_q) && $stable(win_q));

endmodule

bind ireg_port ireg_port_chk #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel    (bus_sel),
  .bus_din    (bus_din),
  .ptr_q      (ptr_q),
  .win_q      (win_q),
  .ptr_wr_evt (ptr_wr_evt),
  .fetch_evt  (fetch_evt),
  .store_evt  (store_evt),
  .drop_evt   (drop_evt),
  .bank_we    (bank_we)
);

// File: tb/tb_ireg_port.sv
module tb_ireg_port;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_loc = 1'b0;
  logic       bus_rd = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_din = '0;
  logic [7:0] bus_dout;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [7:0] mdl [128];

  always #4 clk = ~clk;

  ireg_port dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_loc(bus_loc),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_din(bus_din), .bus_dout(bus_dout)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a, input int salt);
    return 8'((a * 37 + salt * 11 + 5) & 255);
  endfunction

  task automatic bus_write(input logic loc, input logic [7:0] v, input logic sel = 1'b1);
    @(negedge clk);
    bus_sel = sel; bus_loc = loc; bus_wr = 1'b1; bus_din = v;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_din = '0;
  endtask

  // result sampled 1 ns after the strobe rises, inside the same cycle
  task automatic bus_read(input logic loc, output logic [7:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_loc = loc; bus_rd = 1'b1;
    #1 v = bus_dout;
    @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 128; i++) mdl[i] = '0;
  endtask

  task automatic put_reg(input int a, input logic [7:0] v);
    bus_write(1'b0, {1'b0, 7'(a)});
    bus_write(1'b1, v);
    mdl[a] = v;
  endtask

  task automatic get_reg(input int a, output logic [7:0] v);
    bus_write(1'b0, {1'b1, 7'(a)});
    bus_read(1'b1, v);
  endtask

  task automatic t_reset_state();
    logic [7:0] v;
    bus_read(1'b0, v); check("R8 pointer after reset", v, 8'h00);
    bus_read(1'b1, v); check("R8 window after reset", v, 8'h00);
    get_reg(0, v);   check("R8 reg0 after reset", v, 8'h00);
    get_reg(127, v); check("R8 reg127 after reset", v, 8'h00);
    check("R9 dout idle", bus_dout, 8'h00);
  endtask

  task automatic t_pointer_readback();
    logic [7:0] v;
    bus_write(1'b0, 8'h3A); bus_read(1'b0, v); check("R1 pointer write flag", v, 8'h3A);
    bus_write(1'b0, 8'hC5); bus_read(1'b0, v); check("R1 pointer read flag", v, 8'hC5);
  endtask

  task automatic t_fill_and_readback();
    logic [7:0] v;
    for (int i = 0; i < 128; i++) put_reg(i, pat(i, 1));
    for (int i = 0; i < 128; i++) begin
      get_reg(i, v);
      check("R2 R4 register readback", v, mdl[i]);
    end
  endtask

  task automatic t_store_to_window();
    logic [7:0] v;
    put_reg(9, 8'h9E);
    bus_read(1'b1, v); check("R5 window holds stored byte", v, 8'h9E);
    bus_read(1'b0, v); check("R3 pointer write mode", v, 8'h09);
  endtask

  task automatic t_fetch_fresh();
    logic [7:0] v;
    put_reg(64, 8'h11);
    put_reg(64, 8'h77);
    get_reg(64, v); check("R4 fetch sees latest store", v, 8'h77);
    get_reg(65, v); check("R2 neighbour untouched", v, mdl[65]);
  endtask

  task automatic t_drop_in_read_mode();
    logic [7:0] v;
    get_reg(10, v);
    bus_write(1'b1, 8'hEE);
    bus_read(1'b1, v); check("R6 window unchanged", v, mdl[10]);
    get_reg(10, v);    check("R6 register unchanged", v, mdl[10]);
  endtask

  task automatic t_read_no_side_effect();
    logic [7:0] a, b, p;
    get_reg(20, a);
    bus_read(1'b1, b); check("R7 repeat read same", b, a);
    bus_read(1'b0, p); check("R7 pointer unchanged by reads", p, 8'h94);
    check("R7 same cycle value", a, mdl[20]);
  endtask

  task automatic t_deselected();
    logic [7:0] v;
    bus_write(1'b0, 8'h05);
    bus_write(1'b0, 8'h33, 1'b0);
    bus_read(1'b0, v); check("R9 pointer write ignored", v, 8'h05);
    bus_write(1'b1, 8'hAB, 1'b0);
    get_reg(5, v); check("R9 data write ignored", v, mdl[5]);
  endtask

  task automatic t_mid_reset();
    logic [7:0] v;
    put_reg(100, 8'h5A);
    do_reset();
    bus_read(1'b0, v); check("R8 pointer cleared", v, 8'h00);
    get_reg(100, v);   check("R8 register cleared", v, 8'h00);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_pointer_readback();
    t_fill_and_readback();
    t_store_to_window();
    t_fetch_fresh();
    t_drop_in_read_mode();
    t_read_no_side_effect();
    t_deselected();
    t_mid_reset();
    finish_run();
  end

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

endmodule